// File: doc/BRIEF.md
# Hybrid three-level leg gate generator

This block drives the six switches of one leg of a three-level active neutral-point-clamped converter. Four of the switches are slow devices. They work as two complementary pairs: the upper pair is the outer-upper and neutral-lower switches, and the lower pair is the neutral-upper and outer-lower switches. The remaining two switches are a fast inner pair. The sign of a signed, normalized pole-voltage reference chooses which slow pair conducts, so the slow pairs switch once per reference half-period at a fixed 50% duty. The reference magnitude is compared against a triangular carrier count, and the result drives the fast pair, which toggles between the two switch combinations available for the current sign.

Both pairs get a programmable dead time. At every transition the outgoing devices turn off, and the incoming devices turn on only after that many clock cycles. A diagnostic force-zero request overrides the carrier comparison for a chosen number of cycles. During that window the leg stays in the zero state that matches the reference sign. The block also reports a two-bit code for the commanded switching state.

All inputs are sampled on every clock edge. The carrier is assumed to be free-running, and there is no stream handshake, so no back-pressure exists. The outputs update one clock after the inputs they depend on.

Top module: `tl_leg_gate_gen`

## Requirements
- R1: While reset is asserted, all six gate bits are 0 and the state code is 2'b01.
- R2: The gate bits are ordered [0] outer-upper, [1] neutral-upper, [2] neutral-lower, [3] outer-lower, [4] fast-upper, [5] fast-lower. The state codes and their gate patterns are:
  - 2'b00: [0],[2],[4] on.
  - 2'b01: [0],[2],[5] on.
  - 2'b10: [1],[3],[4] on.
  - 2'b11: [1],[3],[5] on.
- R3: A reference of zero or above selects the upper slow pair (bits [0],[2]). A negative reference selects the lower slow pair (bits [1],[3]). The two pairs are never on together.
- R4: For a reference of zero or above, a magnitude strictly greater than the carrier commands 2'b00; otherwise it commands 2'b01. For a negative reference, a magnitude strictly greater than the carrier commands 2'b11; otherwise it commands 2'b10. The outputs reflect inputs sampled one clock earlier.
- R5: When the fast-pair target changes with a dead-time value D > 0, both fast bits stay off for D cycles, and then the new fast bit turns on. When D = 0, the fast pair swaps in the same cycle.
- R6: When the reference sign changes with D > 0, both slow pairs stay off for D cycles, and then the new pair turns on. When D = 0, the slow pairs swap in the same cycle.
- R7: Fast bits [4] and [5] are never on together.
- R8: A force request with length L > 0 commands 2'b01 (reference zero or above) or 2'b10 (reference negative) for L consecutive cycles, starting at the request cycle. Normal modulation follows. A request with L = 0 has no effect. A request made during an active window restarts the count from the new L.
- R9: The dead-time value is captured when an interval starts. Changing the dead-time input during the interval does not change its length.
- R10: The state code shows the commanded state even while a dead interval holds the gates off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | REF_W | Signed normalized pole-voltage reference |
| carrier_i | input | REF_W-1 | Triangular carrier count, unsigned |
| dead_i | input | DT_W | Dead-time length in cycles |
| force_req_i | input | 1 | Force-zero request, sampled each cycle |
| force_len_i | input | FZ_W | Force-zero window length in cycles |
| gate_o | output | 6 | Gate drive bits, order as in R2 |
| leg_state_o | output | 2 | Commanded switching-state code |

## Verification
A stuck or mistimed dead-time counter shows up at the gate bits within D+1 cycles of a transition, either as a gap of the wrong length or as a new device turning on early. A polarity register that is out of step with the reference shows a slow pair that disagrees with bit [1] of the state code one clock after the sign change. A faulty force counter shows up as a zero-state window that is too long or too short, which can be seen directly in the state code after the request. Every one of these faults reaches the ports within a few clocks of the stimulus that exposes it.

// File: rtl/tl_leg_pkg.sv
package tl_leg_pkg;
  typedef enum logic [1:0] {
    ST_POS  = 2'b00,
    ST_ZPOS = 2'b01,
    ST_ZNEG = 2'b10,
    ST_NEG  = 2'b11
  } leg_state_e;

  localparam int GATE_N = 6;
  localparam int G_OUT_HI = 0;
  localparam int G_NTR_HI = 1;
  localparam int G_NTR_LO = 2;
  localparam int G_OUT_LO = 3;
  localparam int G_FST_HI = 4;
  localparam int G_FST_LO = 5;
endpackage

// File: rtl/tl_ref_cmp.sv
module tl_ref_cmp #(
  parameter int REF_W = 12
) (
  input  logic signed [REF_W-1:0] ref_i,
  input  logic        [REF_W-2:0] car_i,
  output logic                    pos_o,
  output logic                    above_o
);
  logic [REF_W-1:0] mag;

  always_comb begin
    pos_o   = !ref_i[REF_W-1];
    mag     = ref_i[REF_W-1] ? REF_W'(-ref_i) : REF_W'(ref_i);
    above_o = mag > {1'b0, car_i};
  end
endmodule

// File: rtl/tl_dead_pair.sv
module tl_dead_pair #(
  parameter int DT_W    = 8,
  parameter bit RST_LVL = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tgt_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            lvl_q;
  logic [DT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= RST_LVL;
      cnt_q <= '0;
      hi_o  <= 1'b0;
      lo_o  <= 1'b0;
    end else if (tgt_i != lvl_q) begin
      lvl_q <= tgt_i;
      if (dead_i == '0) begin
        cnt_q <= '0;
        hi_o  <= tgt_i;
        lo_o  <= !tgt_i;
      end else begin
        cnt_q <= dead_i;
        hi_o  <= 1'b0;
        lo_o  <= 1'b0;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      hi_o  <= (cnt_q == DT_W'(1)) && lvl_q;
      lo_o  <= (cnt_q == DT_W'(1)) && !lvl_q;
    end else begin
      hi_o <= lvl_q;
      lo_o <= !lvl_q;
    end
  end
endmodule

// File: rtl/tl_force_zero.sv
module tl_force_zero #(
  parameter int FZ_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [FZ_W-1:0] len_i,
  output logic            act_o
);
  logic [FZ_W-1:0] cnt_q;
  logic            start;

  assign start = req_i && (len_i != '0);
  assign act_o = start || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= len_i - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tl_leg_gate_gen.sv
module tl_leg_gate_gen
  import tl_leg_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int DT_W  = 8,
  parameter int FZ_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic        [REF_W-2:0] carrier_i,
  input  logic        [DT_W-1:0]  dead_i,
  input  logic                    force_req_i,
  input  logic        [FZ_W-1:0]  force_len_i,
  output logic        [5:0]       gate_o,
  output logic        [1:0]       leg_state_o
);
  logic pos, above, force_act, want_hi;
  logic up_pair, lo_pair, fst_hi, fst_lo;
  leg_state_e state_q;

  tl_ref_cmp #(.REF_W(REF_W)) u_cmp (
    .ref_i(ref_i), .car_i(carrier_i), .pos_o(pos), .above_o(above)
  );

  tl_force_zero #(.FZ_W(FZ_W)) u_force (
    .clk(clk), .rst_n(rst_n), .req_i(force_req_i), .len_i(force_len_i),
    .act_o(force_act)
  );

  // fast-upper on for P and O-, fast-lower on for O+ and N
  always_comb begin
    if (force_act) want_hi = !pos;
    else           want_hi = pos ? above : !above;
  end

  tl_dead_pair #(.DT_W(DT_W), .RST_LVL(1'b1)) u_slow (
    .clk(clk), .rst_n(rst_n), .tgt_i(pos), .dead_i(dead_i),
    .hi_o(up_pair), .lo_o(lo_pair)
  );

  tl_dead_pair #(.DT_W(DT_W), .RST_LVL(1'b0)) u_fast (
    .clk(clk), .rst_n(rst_n), .tgt_i(want_hi), .dead_i(dead_i),
    .hi_o(fst_hi), .lo_o(fst_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ZPOS;
    else        state_q <= leg_state_e'({!pos, !want_hi});
  end

  always_comb begin
    gate_o           = '0;
    gate_o[G_OUT_HI] = up_pair;
    gate_o[G_NTR_LO] = up_pair;
    gate_o[G_NTR_HI] = lo_pair;
    gate_o[G_OUT_LO] = lo_pair;
    gate_o[G_FST_HI] = fst_hi;
    gate_o[G_FST_LO] = fst_lo;
  end

  assign leg_state_o = state_q;
endmodule

// File: rtl/tl_leg_gate_chk.sv
module tl_leg_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] gate_o,
  input logic [1:0] leg_state_o
);
  // R7
  fast_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[4] && gate_o[5]));

  // R3
  slow_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[0] && gate_o[1]));

  // R2
  upper_pair_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o[0] |-> !leg_state_o[1]);

  // R2
  lower_pair_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o[1] |-> leg_state_o[1]);

  // R10
  fast_hi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o[4] |-> !leg_state_o[0]);

  // R10
  fast_lo_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o[5] |-> leg_state_o[0]);
endmodule

bind tl_leg_gate_gen tl_leg_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate_o(gate_o), .leg_state_o(leg_state_o)
);

// File: tb/tl_leg_gate_gen_test.sv
`timescale 1ns/1ps
module tl_leg_gate_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [11:0] ref_i = '0;
  logic [10:0] carrier_i = '0;
  logic [7:0]  dead_i = '0;
  logic        force_req_i = 1'b0;
  logic [9:0]  force_len_i = '0;
  logic [5:0]  gate_o;
  logic [1:0]  leg_state_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tl_leg_gate_gen uut (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .carrier_i(carrier_i),
    .dead_i(dead_i), .force_req_i(force_req_i), .force_len_i(force_len_i),
    .gate_o(gate_o), .leg_state_o(leg_state_o)
  );

  localparam int VN = 10;
  localparam int          V_REF [VN] = '{500, 500, -500, -500, 0, 1, -2048, 2047, 300, 301};
  localparam int          V_CAR [VN] = '{100, 600, 600, 100, 0, 0, 2047, 2047, 300, 300};
  localparam logic [5:0]  V_GAT [VN] = '{6'h15, 6'h25, 6'h1A, 6'h2A, 6'h25, 6'h15, 6'h2A, 6'h25, 6'h25, 6'h15};
  localparam logic [1:0]  V_ST  [VN] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00, 2'b11, 2'b01, 2'b01, 2'b00};

  task automatic chk(input string tag, input logic [5:0] eg, input logic [1:0] es);
    n_chk++;
    if (gate_o !== eg || leg_state_o !== es) begin
      n_bad++;
      $display("FAIL %s: gate=%b state=%b expected gate=%b state=%b", tag, gate_o, leg_state_o, eg, es);
    end
  endtask

  task automatic apply(input int r, input int c, input int d, input bit fq, input int fl);
    ref_i = 12'(r);
    carrier_i = 11'(c);
    dead_i = 8'(d);
    force_req_i = fq;
    force_len_i = 10'(fl);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 6'h00, 2'b01);
    rst_n = 1'b1;

    for (int i = 0; i < VN; i++) begin
      apply(V_REF[i], V_CAR[i], 0, 1'b0, 0);
      chk("R2,R3,R4", V_GAT[i], V_ST[i]);
    end

    // fast dead time, dead value changed mid-interval
    apply(500, 100, 0, 1'b0, 0); chk("R4", 6'h15, 2'b00);
    apply(500, 600, 3, 1'b0, 0); chk("R5,R10", 6'h05, 2'b01);
    apply(500, 600, 1, 1'b0, 0); chk("R9", 6'h05, 2'b01);
    apply(500, 600, 1, 1'b0, 0); chk("R9,R7", 6'h05, 2'b01);
    apply(500, 600, 1, 1'b0, 0); chk("R5", 6'h25, 2'b01);

    // sign change with both pairs moving
    apply(-500, 600, 3, 1'b0, 0); chk("R6,R10", 6'h00, 2'b10);
    apply(-500, 600, 3, 1'b0, 0); chk("R6", 6'h00, 2'b10);
    apply(-500, 600, 3, 1'b0, 0); chk("R6", 6'h00, 2'b10);
    apply(-500, 600, 3, 1'b0, 0); chk("R6", 6'h1A, 2'b10);

    // sign change with fast target unchanged
    apply(500, 100, 2, 1'b0, 0); chk("R6", 6'h10, 2'b00);
    apply(500, 100, 2, 1'b0, 0); chk("R6", 6'h10, 2'b00);
    apply(500, 100, 2, 1'b0, 0); chk("R6", 6'h15, 2'b00);

    // force zero while positive
    apply(500, 100, 0, 1'b1, 3); chk("R8", 6'h25, 2'b01);
    apply(500, 100, 0, 1'b0, 0); chk("R8", 6'h25, 2'b01);
    apply(500, 100, 0, 1'b0, 0); chk("R8", 6'h25, 2'b01);
    apply(500, 100, 0, 1'b0, 0); chk("R8", 6'h15, 2'b00);

    // force zero while negative
    apply(-500, 100, 0, 1'b0, 0); chk("R4", 6'h2A, 2'b11);
    apply(-500, 100, 0, 1'b1, 2); chk("R8", 6'h1A, 2'b10);
    apply(-500, 100, 0, 1'b0, 0); chk("R8", 6'h1A, 2'b10);
    apply(-500, 100, 0, 1'b0, 0); chk("R8", 6'h2A, 2'b11);

    // zero length has no effect
    apply(-500, 100, 0, 1'b1, 0); chk("R8", 6'h2A, 2'b11);

    // restart during an active window
    apply(500, 100, 0, 1'b1, 2); chk("R8", 6'h25, 2'b01);
    apply(500, 100, 0, 1'b1, 3); chk("R8", 6'h25, 2'b01);
    apply(500, 100, 0, 1'b0, 0); chk("R8", 6'h25, 2'b01);
    apply(500, 100, 0, 1'b0, 0); chk("R8", 6'h25, 2'b01);
    apply(500, 100, 0, 1'b0, 0); chk("R8", 6'h15, 2'b00);

    // sign flip inside a force window follows the new sign
    apply(500, 100, 0, 1'b1, 3); chk("R8", 6'h25, 2'b01);
    apply(-500, 100, 0, 1'b0, 0); chk("R8", 6'h1A, 2'b10);
    apply(-500, 100, 0, 1'b0, 0); chk("R8", 6'h1A, 2'b10);
    apply(-500, 100, 0, 1'b0, 0); chk("R8", 6'h2A, 2'b11);

    // reset in mid-run
    rst_n = 1'b0;
    #1;
    chk("R1", 6'h00, 2'b01);
    @(negedge clk);
    chk("R1", 6'h00, 2'b01);
    rst_n = 1'b1;
    apply(500, 600, 0, 1'b0, 0); chk("R1,R4", 6'h25, 2'b01);

    finish_run();
  end
endmodule